// File: doc/BRIEF.md
# Windowed Range Breakpoint Bank

A bank of identical breakpoint channels watches signed datapath samples on the slow clock. Each channel compares its sample against a programmable lower and upper bound. A sample strictly outside the window is a violation. The bounds are held inputs; whatever loads them lies outside this block.

A per-channel mode bit picks one of two behaviours:

- **Trigger mode:** a violation sets a sticky flag and raises that channel's stop request. Both stay set until reset.
- **Count mode:** the stop request is held low, and a saturating counter tallies the cycles that violate.

The stop requests of all channels are combined into one halt line. A debug clock controller uses this line to freeze every clock domain at once.

All state is registered and clears on a synchronous, active-low functional reset.

Top module: `rbk_bank`

## Requirements
- R1: Samples and bounds are 20-bit two's complement. A sample counts as out of range only when it is strictly less than the lower bound or strictly greater than the upper bound. A sample equal to either bound is in range.
- R2: In trigger mode (mode bit 0), the flag is 1 at the clock edge after an out-of-range sample. It stays 1 on later in-range samples for as long as the channel remains in trigger mode.
- R3: In trigger mode, each edge leaves the channel's stop request equal to its flag.
- R4: In count mode (mode bit 1), the stop request is 0. At each edge the flag takes the out-of-range state of the sample presented in that cycle, with no stickiness.
- R5: In count mode, the 9-bit tally rises by exactly 1 at each edge where the sample is out of range, and holds otherwise. In trigger mode the tally holds its value.
- R6: The tally saturates at 511 and does not wrap.
- R7: When the lower bound is greater than the upper bound, every sample is out of range.
- R8: `halt_o` is the OR of all channel stop requests, with no added register stage.
- R9: With `rst_n` low at a clock edge, flag, stop request and tally of every channel become 0 at that edge.
- R10: When a channel switches from trigger to count mode, its stop request and sticky flag drop at the next edge. The tally keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow functional clock |
| rst_n | input | 1 | Synchronous functional reset, active low |
| sample_i | input | NCH*20 | Per-channel signed sample |
| lo_bound_i | input | NCH*20 | Per-channel signed lower bound |
| hi_bound_i | input | NCH*20 | Per-channel signed upper bound |
| count_mode_i | input | NCH | Per-channel mode bit: 0 trigger, 1 count |
| flag_o | output | NCH | Per-channel violation flag |
| stop_req_o | output | NCH | Per-channel clock-stop request |
| tally_o | output | NCH*9 | Per-channel saturating violation count |
| halt_o | output | 1 | OR of all stop requests |

## Verification
Two behaviours can meet in the same cycle:
- One channel is counting a violation while another channel, in trigger mode, is raising a halt.
- A channel changes mode on the same edge as a violation.

The bench provokes the first case by driving channel 0 in count mode and channel 1 in trigger mode, both out of range in the same cycle. It then judges three things: the stop vector shows only channel 1, `halt_o` is set, and channel 0's tally still advances.

The second case is covered by vectors that toggle the mode bit between consecutive samples. The bench checks that the flag and stop request follow the mode in force at that edge, and that the tally neither moves nor clears.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int unsigned RBK_SMP_W   = 20;
    localparam int unsigned RBK_TALLY_W = 9;

    typedef enum logic {
        MODE_TRIGGER = 1'b0,
        MODE_COUNT   = 1'b1
    } rbk_mode_e;
endpackage

// File: rtl/rbk_window.sv
module rbk_window #(
    parameter int unsigned W = rbk_pkg::RBK_SMP_W
) (
    input  logic [W-1:0] sample_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] hi_i,
    output logic         outside_o
);
    logic below;
    logic above;

    always_comb begin
        below     = $signed(sample_i) < $signed(lo_i);
        above     = $signed(sample_i) > $signed(hi_i);
        outside_o = below | above;
    end
endmodule

// File: rtl/rbk_sat_counter.sv
module rbk_sat_counter #(
    parameter int unsigned W = rbk_pkg::RBK_TALLY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] value_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign value_o = cnt_q;
endmodule

// File: rtl/rbk_channel.sv
module rbk_channel
    import rbk_pkg::*;
#(
    parameter int unsigned SMP_W   = RBK_SMP_W,
    parameter int unsigned TALLY_W = RBK_TALLY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SMP_W-1:0]   sample_i,
    input  logic [SMP_W-1:0]   lo_i,
    input  logic [SMP_W-1:0]   hi_i,
    input  logic               count_mode_i,
    output logic               flag_o,
    output logic               stop_o,
    output logic [TALLY_W-1:0] tally_o
);
    typedef struct packed {
        logic flag;
        logic stop;
    } chan_state_t;

    chan_state_t st_d;
    chan_state_t st_q;
    rbk_mode_e   mode;
    logic        outside;
    logic        tally_inc;

    rbk_window #(.W(SMP_W)) u_window (
        .sample_i (sample_i),
        .lo_i     (lo_i),
        .hi_i     (hi_i),
        .outside_o(outside)
    );

    always_comb begin
        mode      = rbk_mode_e'(count_mode_i);
        st_d      = st_q;
        tally_inc = 1'b0;
        if (mode == MODE_COUNT) begin
            st_d.stop = 1'b0;
            st_d.flag = outside;
            tally_inc = outside;
        end else begin
            st_d.stop = st_q.stop | outside;
            st_d.flag = st_d.stop;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    rbk_sat_counter #(.W(TALLY_W)) u_tally (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (tally_inc),
        .value_o(tally_o)
    );

    assign flag_o = st_q.flag;
    assign stop_o = st_q.stop;
endmodule

// File: rtl/rbk_bank.sv
module rbk_bank
    import rbk_pkg::*;
#(
    parameter int unsigned NCH     = 2,
    parameter int unsigned SMP_W   = RBK_SMP_W,
    parameter int unsigned TALLY_W = RBK_TALLY_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0][SMP_W-1:0]     sample_i,
    input  logic [NCH-1:0][SMP_W-1:0]     lo_bound_i,
    input  logic [NCH-1:0][SMP_W-1:0]     hi_bound_i,
    input  logic [NCH-1:0]                count_mode_i,
    output logic [NCH-1:0]                flag_o,
    output logic [NCH-1:0]                stop_req_o,
    output logic [NCH-1:0][TALLY_W-1:0]   tally_o,
    output logic                          halt_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        rbk_channel #(
            .SMP_W  (SMP_W),
            .TALLY_W(TALLY_W)
        ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .sample_i    (sample_i[g]),
            .lo_i        (lo_bound_i[g]),
            .hi_i        (hi_bound_i[g]),
            .count_mode_i(count_mode_i[g]),
            .flag_o      (flag_o[g]),
            .stop_o      (stop_req_o[g]),
            .tally_o     (tally_o[g])
        );
    end

    assign halt_o = |stop_req_o;
endmodule

// File: rtl/rbk_bank_chk.sv
module rbk_bank_chk #(
    parameter int unsigned NCH     = 2,
    parameter int unsigned SMP_W   = 20,
    parameter int unsigned TALLY_W = 9
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NCH-1:0][SMP_W-1:0]   sample_i,
    input logic [NCH-1:0][SMP_W-1:0]   lo_bound_i,
    input logic [NCH-1:0][SMP_W-1:0]   hi_bound_i,
    input logic [NCH-1:0]              count_mode_i,
    input logic [NCH-1:0]              flag_o,
    input logic [NCH-1:0]              stop_req_o,
    input logic [NCH-1:0][TALLY_W-1:0] tally_o,
    input logic                        halt_o
);
    localparam logic [TALLY_W-1:0] TALLY_TOP = {TALLY_W{1'b1}};

    AST_COUNT_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stop_req_o & $past(count_mode_i)) == '0)); // R4

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic viol;
        assign viol = ($signed(sample_i[g]) < $signed(lo_bound_i[g]))
                   || ($signed(sample_i[g]) > $signed(hi_bound_i[g]));

        AST_TRIG_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
            (!count_mode_i[g] && viol) |=> (halt_o && flag_o[g])); // R8

        AST_STICKY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_req_o[g] && !count_mode_i[g]) |=> (stop_req_o[g] && flag_o[g])); // R2

        AST_STOP_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            !count_mode_i[g] |=> (stop_req_o[g] == flag_o[g])); // R3

        AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (tally_o[g] == TALLY_TOP) |=> (tally_o[g] == TALLY_TOP)); // R6

        AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ((tally_o[g] == $past(tally_o[g]))
                || (tally_o[g] == $past(tally_o[g]) + 1'b1))); // R5
    end
endmodule

bind rbk_bank rbk_bank_chk #(
    .NCH    (NCH),
    .SMP_W  (SMP_W),
    .TALLY_W(TALLY_W)
) u_rbk_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (sample_i),
    .lo_bound_i  (lo_bound_i),
    .hi_bound_i  (hi_bound_i),
    .count_mode_i(count_mode_i),
    .flag_o      (flag_o),
    .stop_req_o  (stop_req_o),
    .tally_o     (tally_o),
    .halt_o      (halt_o)
);

// File: tb/sim_rbk_bank.sv
module sim_rbk_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int NVEC = 10;

    // row: {sample[19:0], mode, exp_flag, exp_stop, exp_tally[8:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {20'h00064, 1'b1, 1'b0, 1'b0, 9'd0},
        {20'h00065, 1'b1, 1'b1, 1'b0, 9'd1},
        {20'hFFF9C, 1'b1, 1'b0, 1'b0, 9'd1},
        {20'hFFF9B, 1'b1, 1'b1, 1'b0, 9'd2},
        {20'h80000, 1'b1, 1'b1, 1'b0, 9'd3},
        {20'h00000, 1'b0, 1'b0, 1'b0, 9'd3},
        {20'h7FFFF, 1'b0, 1'b1, 1'b1, 9'd3},
        {20'h00000, 1'b0, 1'b1, 1'b1, 9'd3},
        {20'h00000, 1'b1, 1'b0, 1'b0, 9'd3},
        {20'h00000, 1'b0, 1'b0, 1'b0, 9'd3}
    };
    string vec_req [NVEC] = '{"R1", "R5", "R4", "R1", "R5",
                              "R5", "R2", "R3", "R10", "R10"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0][19:0] sample = '0;
    logic [NCH-1:0][19:0] lo_b = '0;
    logic [NCH-1:0][19:0] hi_b = '0;
    logic [NCH-1:0]       mode = '0;
    logic [NCH-1:0]       flag;
    logic [NCH-1:0]       stop;
    logic [NCH-1:0][8:0]  tally;
    logic                 halt;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rbk_bank #(.NCH(NCH)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_i    (sample),
        .lo_bound_i  (lo_b),
        .hi_bound_i  (hi_b),
        .count_mode_i(mode),
        .flag_o      (flag),
        .stop_req_o  (stop),
        .tally_o     (tally),
        .halt_o      (halt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        lo_b[0] = 20'hFFF9C;   // -100
        hi_b[0] = 20'h00064;   // +100
        lo_b[1] = 20'hFFFF6;   // -10
        hi_b[1] = 20'h0000A;   // +10
        mode    = 2'b11;
        tick();
        tick();
        // r9_ reset state
        chk("R9 reset state", {13'd0, flag, stop, halt, tally[0], tally[1]}, 32'd0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            sample[0] = VEC[k][31:12];
            mode[0]   = VEC[k][11];
            tick();
            chk(vec_req[k], {21'd0, flag[0], stop[0], halt, tally[0]},
                {21'd0, VEC[k][10], VEC[k][9], VEC[k][9], VEC[k][8:0]});
        end

        // R8: ch0 counts while ch1 triggers in the same cycle
        sample[0] = 20'h00200; mode[0] = 1'b1;
        sample[1] = 20'h00020; mode[1] = 1'b0;
        tick();
        chk("R8 stop vector", {30'd0, stop}, 32'b10);
        chk("R8 halt", {31'd0, halt}, 32'd1);
        chk("R5 tally during halt", {23'd0, tally[0]}, 32'd4);

        // R8: count-mode violation alone raises no halt
        rst_n = 1'b0;
        tick();
        chk("R9 mid-run reset", {13'd0, flag, stop, halt, tally[0], tally[1]}, 32'd0);
        rst_n = 1'b1;
        mode = 2'b11;
        sample[0] = 20'h00200; sample[1] = 20'h00020;
        tick();
        chk("R8 no halt in count", {29'd0, stop, halt}, 32'd0);
        chk("R4 flags in count", {30'd0, flag}, 32'b11);

        // R7: inverted bounds on ch1, count mode
        lo_b[1] = 20'h00032;   // +50
        hi_b[1] = 20'hFFFCE;   // -50
        sample[1] = 20'h00000; tick();
        sample[1] = 20'h0003C; tick();
        sample[1] = 20'hFFFC4; tick();
        chk("R7 inverted bounds tally", {23'd0, tally[1]}, 32'd4);
        chk("R7 inverted bounds flag", {31'd0, flag[1]}, 32'd1);

        // R6: saturate
        for (int n = 0; n < 600; n++) tick();
        chk("R6 saturation", {23'd0, tally[1]}, 32'd511);
        chk("R6 no stop while counting", {31'd0, stop[1]}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule